// File: doc/BRIEF.md
# Multiprocessor Occupancy Calculator

This block takes one kernel launch configuration and works out how many thread blocks, and so how many warps, can be resident on a single multiprocessor at once. The inputs are threads per block, registers per thread, scratchpad bytes per block and the scratchpad capacity of the multiprocessor. Each resource gives its own ceiling on resident blocks. The block reports the smallest ceiling as the resident block count, the resident warp count, an 8-bit occupancy fraction, and a 2-bit code that names the resource that set the result.

A request is made by pulsing `start` with the configuration on the inputs. The block latches the inputs and runs three divisions in turn on a single restoring divider, one quotient bit per cycle. It then picks the binding limit and pulses `done`. The results stay on the outputs until the next request finishes. Threads are grouped in warps of 32, and a partial warp costs a full warp of registers and of warp slots.

Top module: `mp_occupancy`

## Requirements
- R1: Warps per block is threads per block divided by 32, rounded up. Resident warps are always resident blocks times this value.
- R2: The register ceiling is floor(65536 / (warps_per_block × 32 × registers_per_thread)). If registers per thread is 0, registers impose no ceiling.
- R3: The scratchpad ceiling is floor(capacity / bytes_per_block). If bytes per block is 0, scratchpad imposes no ceiling. A capacity of 0 with a nonzero demand gives a ceiling of 0.
- R4: The warp ceiling is floor(64 / warps_per_block). This also enforces the 2048-thread cap. A request with 0 threads per block gives a ceiling of 0.
- R5: Resident blocks never exceed 32.
- R6: `res_blocks` is the smallest of the four ceilings. `bind_code` is 0 for registers, 1 for scratchpad, 2 for warps/threads and 3 for the 32-block cap. On a tie the lower code wins.
- R7: `res_warps` equals `res_blocks` × warps per block and never exceeds 64.
- R8: `occ_frac` equals floor(res_warps × 255 / 64), so 64 warps reads 255 and 32 warps reads 127.
- R9: `done` is high for exactly one cycle. It rises 3×(DW+1)+1 clock edges after the edge that samples `start`, where DW is the divider width (21 at defaults, giving 67). `busy` is high from the sampling edge until `done` rises, and is low while `done` is high.
- R10: While `busy` is high, `start` and all configuration inputs are ignored. The outputs change only on the edge that raises `done`, and they then hold.
- R11: A `start` sampled in the cycle where `done` is high begins a new request at once.
- R12: After reset, `busy`, `done` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| thr_per_blk | input | 12 | Threads per block |
| reg_per_thr | input | 8 | Registers per thread, 0 = no limit |
| scr_per_blk | input | 18 | Scratchpad bytes per block, 0 = no limit |
| scr_total | input | 18 | Scratchpad capacity in bytes |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| res_blocks | output | 6 | Resident blocks |
| res_warps | output | 7 | Resident warps |
| occ_frac | output | 8 | Occupancy, 255 = 64 warps |
| bind_code | output | 2 | Binding limit code |

## Verification
The completion strobe of one request and the acceptance of the next request can land in the same cycle. The bench provokes this by raising `start` with a second configuration on the very cycle it sees `done`. It checks that the first result is correct in that cycle, and that the second result follows with the full latency. A near-exhaustive sweep over thread counts, register counts, scratchpad demands and two capacities covers ties and zero inputs. Each result is compared against arithmetic computed in the bench, and the latency is checked on every run.

// File: rtl/mp_occupancy.sv
module mp_occupancy #(
  parameter int TW         = 12,
  parameter int RW         = 8,
  parameter int SW         = 18,
  parameter int WARP       = 32,
  parameter int REG_POOL   = 65536,
  parameter int MAX_WARPS  = 64,
  parameter int MAX_BLOCKS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] thr_per_blk,
  input  logic [RW-1:0] reg_per_thr,
  input  logic [SW-1:0] scr_per_blk,
  input  logic [SW-1:0] scr_total,
  output logic          busy,
  output logic          done,
  output logic [5:0]    res_blocks,
  output logic [6:0]    res_warps,
  output logic [7:0]    occ_frac,
  output logic [1:0]    bind_code
);
  localparam int LW    = $clog2(WARP);
  localparam int WPBW  = TW - LW + 1;
  localparam int NEEDW = WPBW + LW + RW;
  localparam int POOLW = $clog2(REG_POOL) + 1;
  localparam int DW0   = (NEEDW > SW) ? NEEDW : SW;
  localparam int DW    = (DW0 > POOLW) ? DW0 : POOLW;
  localparam int CW    = $clog2(DW);
  localparam int PW    = DW + WPBW;

  typedef enum logic [2:0] {S_IDLE, S_REG, S_SCR, S_WARP, S_FIN} st_t;

  st_t            st;
  logic           ld, dz;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  rem, quo, dsr;
  logic [WPBW-1:0] wpb_q;
  logic [RW-1:0]  rpt_q;
  logic [SW-1:0]  scr_q, cap_q;
  logic [DW-1:0]  lim_reg, lim_scr, lim_wrp;

  logic [TW:0]    thr_rnd;
  logic [WPBW-1:0] wpb_in;
  logic [NEEDW-1:0] reg_need;
  logic [DW-1:0]  op_dvd, op_dsr;
  logic [DW:0]    sh;
  logic           ge;
  logic [DW-1:0]  nrem, nquo, qres;
  logic [DW-1:0]  sel_blk;
  logic [1:0]     sel_code;

  assign thr_rnd  = {1'b0, thr_per_blk} + (TW+1)'(WARP - 1);
  assign wpb_in   = thr_rnd[TW:LW];
  assign reg_need = NEEDW'({wpb_q, {LW{1'b0}}}) * NEEDW'(rpt_q);
  assign busy     = (st != S_IDLE);

  always_comb begin
    case (st)
      S_REG:   begin op_dvd = DW'(REG_POOL);  op_dsr = DW'(reg_need); end
      S_SCR:   begin op_dvd = DW'(cap_q);     op_dsr = DW'(scr_q);    end
      S_WARP:  begin op_dvd = DW'(MAX_WARPS); op_dsr = DW'(wpb_q);    end
      default: begin op_dvd = '0;             op_dsr = '0;            end
    endcase
  end

  assign sh   = {rem, quo[DW-1]};
  assign ge   = (sh >= {1'b0, dsr});
  assign nrem = ge ? (sh[DW-1:0] - dsr) : sh[DW-1:0];
  assign nquo = {quo[DW-2:0], ge};
  assign qres = dz ? ((st == S_WARP) ? '0 : '1) : nquo;

  always_comb begin
    sel_blk  = lim_reg;
    sel_code = 2'd0;
    if (lim_scr < sel_blk) begin sel_blk = lim_scr; sel_code = 2'd1; end
    if (lim_wrp < sel_blk) begin sel_blk = lim_wrp; sel_code = 2'd2; end
    if (DW'(MAX_BLOCKS) < sel_blk) begin sel_blk = DW'(MAX_BLOCKS); sel_code = 2'd3; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ld         <= 1'b0;
      dz         <= 1'b0;
      cnt        <= '0;
      rem        <= '0;
      quo        <= '0;
      dsr        <= '0;
      wpb_q      <= '0;
      rpt_q      <= '0;
      scr_q      <= '0;
      cap_q      <= '0;
      lim_reg    <= '0;
      lim_scr    <= '0;
      lim_wrp    <= '0;
      res_blocks <= '0;
      res_warps  <= '0;
      occ_frac   <= '0;
      bind_code  <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          wpb_q <= wpb_in;
          rpt_q <= reg_per_thr;
          scr_q <= scr_per_blk;
          cap_q <= scr_total;
          ld    <= 1'b1;
          st    <= S_REG;
        end
        S_REG, S_SCR, S_WARP: begin
          if (ld) begin
            rem <= '0;
            quo <= op_dvd;
            dsr <= op_dsr;
            dz  <= (op_dsr == '0);
            cnt <= '0;
            ld  <= 1'b0;
          end else begin
            rem <= nrem;
            quo <= nquo;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) begin
              ld <= 1'b1;
              case (st)
                S_REG:   begin lim_reg <= qres; st <= S_SCR;  end
                S_SCR:   begin lim_scr <= qres; st <= S_WARP; end
                default: begin lim_wrp <= qres; st <= S_FIN;  end
              endcase
            end
          end
        end
        S_FIN: begin
          res_blocks <= 6'(sel_blk);
          res_warps  <= 7'(PW'(sel_blk) * PW'(wpb_q));
          occ_frac   <= 8'((PW'(sel_blk) * PW'(wpb_q) * PW'(255)) / PW'(MAX_WARPS));
          bind_code  <= sel_code;
          done       <= 1'b1;
          ld         <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n) done |-> res_blocks <= MAX_BLOCKS); // R5
  AST_WARP_CAP: assert property (@(posedge clk) disable iff (!rst_n) done |-> res_warps <= MAX_WARPS); // R7
  AST_CAP_CODE: assert property (@(posedge clk) disable iff (!rst_n) (done && bind_code == 2'd3) |-> res_blocks == MAX_BLOCKS); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(res_blocks) || !$stable(bind_code) || !$stable(occ_frac)) |-> done); // R10
endmodule

// File: tb/tb_mp_occupancy.sv
module tb_mp_occupancy;
  localparam int LAT = 3 * (21 + 1) + 1;
  localparam int INF = 1 << 30;

  logic clk = 0, rst_n = 0, start = 0;
  logic [11:0] thr = 0;
  logic [7:0]  rpt = 0;
  logic [17:0] spb = 0, cap = 0;
  logic busy, done;
  logic [5:0] blocks;
  logic [6:0] warps;
  logic [7:0] occ;
  logic [1:0] code;
  int n_tests = 0, n_fail = 0;

  mp_occupancy dut (.clk(clk), .rst_n(rst_n), .start(start), .thr_per_blk(thr),
    .reg_per_thr(rpt), .scr_per_blk(spb), .scr_total(cap), .busy(busy), .done(done),
    .res_blocks(blocks), .res_warps(warps), .occ_frac(occ), .bind_code(code));

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input int t, input int r, input int s, input int c,
                       output int eb, output int ec, output int ew, output int eo);
    int wpb, rl, sl, wl;
    wpb = (t + 31) / 32;
    rl = (r == 0 || wpb == 0) ? INF : 65536 / (wpb * 32 * r);
    sl = (s == 0) ? INF : c / s;
    wl = (wpb == 0) ? 0 : 64 / wpb;
    eb = rl; ec = 0;
    if (sl < eb) begin eb = sl; ec = 1; end
    if (wl < eb) begin eb = wl; ec = 2; end
    if (32 < eb) begin eb = 32; ec = 3; end
    ew = eb * wpb;
    eo = ew * 255 / 64;
  endtask

  task automatic kick(input int t, input int r, input int s, input int c);
    thr = 12'(t); rpt = 8'(r); spb = 18'(s); cap = 18'(c);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_res(input string req, input int t, input int r, input int s, input int c);
    int eb, ec, ew, eo;
    model(t, r, s, c, eb, ec, ew, eo);
    chk(req, "blocks", int'(blocks), eb);
    chk(req, "code", int'(code), ec);
    chk("R7", "warps", int'(warps), ew);
    chk("R8", "occ", int'(occ), eo);
  endtask

  task automatic run(input string req, input int t, input int r, input int s, input int c);
    int n;
    kick(t, r, s, c);
    wait_done(n);
    chk("R9", "latency", n - 1, LAT);
    check_res(req, t, r, s, c);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int tl[14] = '{0, 1, 31, 32, 33, 64, 96, 100, 128, 256, 512, 1024, 2048, 4095};
    int rl[7]  = '{0, 16, 32, 33, 64, 128, 255};
    int sl[5]  = '{0, 1024, 32768, 49152, 98304};
    int n;
    @(negedge clk);
    @(negedge clk);
    chk("R12", "busy", int'(busy), 0);
    chk("R12", "done", int'(done), 0);
    chk("R12", "blocks", int'(blocks), 0);
    chk("R12", "occ", int'(occ), 0);
    rst_n = 1;
    @(negedge clk);

    run("R2", 256, 64, 0, 98304);
    chk("R2", "blocks 4", int'(blocks), 4);
    chk("R8", "occ half", int'(occ), 127);
    run("R3", 256, 0, 32768, 98304);
    chk("R3", "blocks 3", int'(blocks), 3);
    run("R4", 128, 0, 0, 98304);
    chk("R4", "blocks 16", int'(blocks), 16);
    chk("R4", "code warps", int'(code), 2);
    run("R4", 0, 32, 1024, 98304);
    chk("R4", "zero threads", int'(blocks), 0);
    run("R5", 32, 0, 0, 0);
    chk("R5", "cap", int'(blocks), 32);
    chk("R5", "code cap", int'(code), 3);
    run("R6", 256, 32, 0, 98304);
    chk("R6", "tie reg/warp", int'(code), 0);
    run("R1", 33, 0, 0, 98304);
    chk("R1", "warps 64", int'(warps), 64);
    chk("R6", "tie warp/cap", int'(code), 2);
    chk("R8", "occ full", int'(occ), 255);
    run("R3", 64, 0, 1024, 0);
    chk("R3", "zero capacity", int'(blocks), 0);

    kick(256, 64, 0, 98304);
    repeat (5) @(negedge clk);
    thr = 12'd32; rpt = 8'd0; spb = 18'd0; cap = 18'd0;
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done(n);
    chk("R10", "latency", n - 1, LAT - 6);
    check_res("R10", 256, 64, 0, 98304);
    repeat (3) @(negedge clk);
    chk("R10", "hold blocks", int'(blocks), 4);
    chk("R10", "busy low", int'(busy), 0);

    kick(128, 0, 0, 98304);
    wait_done(n);
    check_res("R11", 128, 0, 0, 98304);
    kick(256, 0, 32768, 98304);
    chk("R11", "accepted", int'(busy), 1);
    wait_done(n);
    chk("R11", "latency", n - 1, LAT);
    check_res("R11", 256, 0, 32768, 98304);

    foreach (tl[i]) foreach (rl[j]) foreach (sl[k]) begin
      run("R6", tl[i], rl[j], sl[k], 98304);
      run("R6", tl[i], rl[j], sl[k], 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule